// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Filtering Sleep

This block turns an asynchronous serial line into parallel words. It takes 7, 8 or 9 data bits, least significant bit first. Each frame has a start bit, an optional even or odd parity bit, and one or two stop bits. The line is sampled on a 16x oversampling tick supplied from outside. Each complete frame is placed in a 9-bit receive buffer, and a set of status flags is updated at that moment. The flags are: data ready, overrun, framing error, parity error, and a summary error that is the OR of the three error flags. A one-cycle interrupt request fires whenever the data-ready flag goes from 0 to 1.

For multidrop links, a sleep input makes the receiver drop every frame whose most significant data bit is 0. Such a frame leaves the buffer, the flags and the interrupt untouched. Frames with that bit set are received as usual. Software on each node uses address frames (top bit 1) to decide whether to leave sleep mode and accept the data frames (top bit 0) that follow.

An optional active-low ready-to-send output tells the far end when the receiver can take a frame. It is low while the receiver is enabled and waiting. It is high during reception and while the receiver is disabled.

Top module: `uart_rx_mp`

## Requirements
- R1: The frame length is set by `len_i`: 0 gives 7 data bits, 1 gives 8, and 2 gives 9 (3 behaves as 8). Bits arrive least significant first. The buffer `rbuf_o` holds the word in its low bits, and every bit above the frame length reads 0.
- R2: Parity is set by `par_i`: 0 or 3 means no parity bit, 1 means even, 2 means odd. `perr_o` is set when the data bits plus the received parity bit have an odd count of ones (even mode) or an even count (odd mode).
- R3: `two_stop_i`=1 requires two stop bits. `frm_o` is set when any required stop bit is sampled low.
- R4: After the last stop bit has been sampled, the received word is copied into `rbuf_o` and `rdy_o` goes to 1. The buffer changes at no other time.
- R5: `irq_o` pulses high for exactly one cycle when `rdy_o` changes from 0 to 1. It never pulses for a transfer that finds `rdy_o` already set.
- R6: `ovr_o` is set when a frame is transferred while `rdy_o` is still 1. The buffer then holds the newer word.
- R7: `sum_o` equals the OR of `ovr_o`, `frm_o` and `perr_o`.
- R8: The error flags accumulate over transfers. A one-cycle pulse on `rd_lo_i`, or `rx_en_i` low, clears `rdy_o`, `ovr_o`, `frm_o`, `perr_o` and `sum_o` on the next clock edge.
- R9: With `sleep_i`=1, a frame whose most significant data bit is 0 is discarded. That bit is bit 6, 7 or 8 for 7-, 8- or 9-bit frames. The buffer, all flags and `irq_o` stay unchanged.
- R10: With `sleep_i`=1, a frame whose most significant data bit is 1 is received exactly as in normal mode.
- R11: A low pulse that is no longer low when checked at the middle of the start bit is treated as noise. It produces no transfer and no change in the ready-to-send output.
- R12: With `rts_en_i`=1, `rts_n_o` is high while `rx_en_i` is 0. It is low from the cycle after the receiver is enabled. It goes high once a start bit is confirmed, and goes low again when the frame ends. With `rts_en_i`=0 it stays high.
- R13: After reset, the buffer, all flags and `irq_o` are 0, and `rts_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial data line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en_i | input | 1 | Receive enable; 0 holds the receiver idle and clears the flags |
| len_i | input | 2 | Data bits: 0=7, 1=8, 2=9, 3=8 |
| par_i | input | 2 | Parity: 0/3 none, 1 even, 2 odd |
| two_stop_i | input | 1 | 1 = two stop bits required |
| sleep_i | input | 1 | Address-filtering sleep mode |
| rts_en_i | input | 1 | Enables the ready-to-send output |
| rd_lo_i | input | 1 | Buffer low-byte read strobe; clears the flags |
| rbuf_o | output | 9 | Receive buffer |
| rdy_o | output | 1 | Data-ready flag |
| ovr_o | output | 1 | Overrun flag |
| frm_o | output | 1 | Framing-error flag |
| perr_o | output | 1 | Parity-error flag |
| sum_o | output | 1 | Summary error flag |
| irq_o | output | 1 | Receive interrupt request pulse |
| rts_n_o | output | 1 | Active-low ready-to-send |

## Verification
The transfer into the buffer happens on the first clock after the mid-bit sample of the last stop bit. That sample is taken a tick plus two synchronizer cycles behind the line. The buffer, the flags and the interrupt pulse therefore all change on the same edge, about half a bit time before the stop bit ends. The bench waits until the stop bit has finished and then idles a further one and a half bit times before it samples the outputs. This leaves a wide margin while still checking before the next frame starts. The interrupt pulse is counted at every falling edge across the whole frame. A read strobe or a disable is checked at the very next falling edge, and the ready-to-send output is checked one cycle after enable and in the middle of the first data bit.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int unsigned WORD_W = 9;

    typedef enum logic [1:0] {
        LEN7   = 2'd0,
        LEN8   = 2'd1,
        LEN9   = 2'd2,
        LEN8_R = 2'd3
    } rx_len_e;

    typedef enum logic [1:0] {
        PAR_NONE   = 2'd0,
        PAR_EVEN   = 2'd1,
        PAR_ODD    = 2'd2,
        PAR_NONE_R = 2'd3
    } rx_par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              par_bad;
        logic              stop_bad;
    } rx_frame_t;

    typedef struct packed {
        logic ready;
        logic overrun;
        logic framing;
        logic parity;
        logic summary;
    } rx_flags_t;

    function automatic logic [3:0] frame_bits(input rx_len_e len);
        case (len)
            LEN7:    frame_bits = 4'd7;
            LEN9:    frame_bits = 4'd9;
            default: frame_bits = 4'd8;
        endcase
    endfunction

    function automatic logic parity_used(input rx_par_e p);
        parity_used = (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Bits enter the shifter from the top, so a short frame sits high
    // and must be moved down to bit 0.
    function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sh,
                                                     input rx_len_e len);
        case (len)
            LEN7:    align_word = {2'b00, sh[8:2]};
            LEN9:    align_word = sh;
            default: align_word = {1'b0, sh[8:1]};
        endcase
    endfunction

    function automatic logic top_bit(input logic [WORD_W-1:0] w, input rx_len_e len);
        case (len)
            LEN7:    top_bit = w[6];
            LEN9:    top_bit = w[8];
            default: top_bit = w[7];
        endcase
    endfunction

endpackage

// File: rtl/urx_sampler.sv
`timescale 1ns/1ps
module urx_sampler
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      rx_async,
    input  logic      tick,
    input  rx_len_e   len,
    input  rx_par_e   par,
    input  logic      two_stop,
    output logic      start_ok,
    output logic      done,
    output rx_frame_t frame
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rx_async;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_async};
            end
        end
    endgenerate
    assign rxd = sync_q[SYNC_STAGES-1];

    rx_state_e          st;
    logic [CW-1:0]      cnt;
    logic [3:0]         bitn;
    logic [WORD_W-1:0]  sh;
    logic               pacc;
    logic               perr_q;
    logic               serr_q;
    logic [3:0]         nb;
    logic               bit_mid;
    logic               par_now_bad;

    assign nb      = frame_bits(len);
    assign bit_mid = tick && (cnt == LAST);

    always_comb begin
        if (par == PAR_ODD) par_now_bad = ~(pacc ^ rxd);
        else                par_now_bad =  (pacc ^ rxd);
    end

    always_ff @(posedge clk) begin
        start_ok <= 1'b0;
        done     <= 1'b0;
        if (rst || !en) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            pacc   <= 1'b0;
            perr_q <= 1'b0;
            serr_q <= 1'b0;
            frame  <= '0;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!rxd) st <= ST_START;
                end
                ST_START: begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        if (rxd) begin
                            st <= ST_IDLE;
                        end else begin
                            st       <= ST_DATA;
                            bitn     <= '0;
                            sh       <= '0;
                            pacc     <= 1'b0;
                            perr_q   <= 1'b0;
                            serr_q   <= 1'b0;
                            start_ok <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    cnt <= cnt + 1'b1;
                    if (bit_mid) begin
                        sh   <= {rxd, sh[WORD_W-1:1]};
                        pacc <= pacc ^ rxd;
                        bitn <= bitn + 4'd1;
                        if (bitn == nb - 4'd1)
                            st <= parity_used(par) ? ST_PAR : ST_STOP1;
                    end
                end
                ST_PAR: begin
                    cnt <= cnt + 1'b1;
                    if (bit_mid) begin
                        perr_q <= par_now_bad;
                        st     <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    cnt <= cnt + 1'b1;
                    if (bit_mid) begin
                        if (two_stop) begin
                            serr_q <= ~rxd;
                            st     <= ST_STOP2;
                        end else begin
                            frame.word     <= align_word(sh, len);
                            frame.par_bad  <= perr_q;
                            frame.stop_bad <= ~rxd;
                            done           <= 1'b1;
                            st             <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    cnt <= cnt + 1'b1;
                    if (bit_mid) begin
                        frame.word     <= align_word(sh, len);
                        frame.par_bad  <= perr_q;
                        frame.stop_bad <= serr_q | ~rxd;
                        done           <= 1'b1;
                        st             <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/urx_status.sv
`timescale 1ns/1ps
module urx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sleep,
    input  rx_len_e           len,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              rd,
    output logic [WORD_W-1:0] rbuf,
    output rx_flags_t         flags,
    output logic              irq
);
    logic accept;
    logic nxt_ovr, nxt_frm, nxt_par;

    // In sleep mode only frames carrying an address marker are taken.
    assign accept  = done && (!sleep || top_bit(frame.word, len));
    assign nxt_ovr = flags.overrun | flags.ready;
    assign nxt_frm = flags.framing | frame.stop_bad;
    assign nxt_par = flags.parity  | frame.par_bad;

    always_ff @(posedge clk) begin
        irq <= 1'b0;
        if (rst) begin
            rbuf  <= '0;
            flags <= '0;
        end else if (!en) begin
            flags <= '0;
        end else if (accept) begin
            rbuf          <= frame.word;
            flags.ready   <= 1'b1;
            flags.overrun <= nxt_ovr;
            flags.framing <= nxt_frm;
            flags.parity  <= nxt_par;
            flags.summary <= nxt_ovr | nxt_frm | nxt_par;
            irq           <= ~flags.ready;
        end else if (rd) begin
            flags <= '0;
        end
    end
endmodule

// File: rtl/urx_rts.sv
`timescale 1ns/1ps
module urx_rts (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rts_en,
    input  logic start_ok,
    input  logic done,
    output logic rts_n
);
    logic en_q;
    logic ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ready <= 1'b0;
        end else begin
            en_q <= en;
            if (!en)           ready <= 1'b0;
            else if (!en_q)    ready <= 1'b1;
            else if (start_ok) ready <= 1'b0;
            else if (done)     ready <= 1'b1;
        end
    end

    assign rts_n = rts_en ? ~ready : 1'b1;
endmodule

// File: rtl/uart_rx_mp.sv
`timescale 1ns/1ps
module uart_rx_mp
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick16_i,
    input  logic       rx_en_i,
    input  logic [1:0] len_i,
    input  logic [1:0] par_i,
    input  logic       two_stop_i,
    input  logic       sleep_i,
    input  logic       rts_en_i,
    input  logic       rd_lo_i,
    output logic [8:0] rbuf_o,
    output logic       rdy_o,
    output logic       ovr_o,
    output logic       frm_o,
    output logic       perr_o,
    output logic       sum_o,
    output logic       irq_o,
    output logic       rts_n_o
);
    rx_len_e   len;
    rx_par_e   par;
    rx_frame_t frame;
    rx_flags_t flags;
    logic      start_ok;
    logic      done;

    assign len = rx_len_e'(len_i);
    assign par = rx_par_e'(par_i);

    urx_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en_i),
        .rx_async (rx_i),
        .tick     (tick16_i),
        .len      (len),
        .par      (par),
        .two_stop (two_stop_i),
        .start_ok (start_ok),
        .done     (done),
        .frame    (frame)
    );

    urx_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .en    (rx_en_i),
        .sleep (sleep_i),
        .len   (len),
        .done  (done),
        .frame (frame),
        .rd    (rd_lo_i),
        .rbuf  (rbuf_o),
        .flags (flags),
        .irq   (irq_o)
    );

    urx_rts u_rts (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en_i),
        .rts_en   (rts_en_i),
        .start_ok (start_ok),
        .done     (done),
        .rts_n    (rts_n_o)
    );

    assign rdy_o  = flags.ready;
    assign ovr_o  = flags.overrun;
    assign frm_o  = flags.framing;
    assign perr_o = flags.parity;
    assign sum_o  = flags.summary;
endmodule

// File: rtl/urx_chk.sv
`timescale 1ns/1ps
module urx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en_i,
    input logic       rts_en_i,
    input logic [8:0] rbuf_o,
    input logic       rdy_o,
    input logic       ovr_o,
    input logic       frm_o,
    input logic       perr_o,
    input logic       sum_o,
    input logic       irq_o,
    input logic       rts_n_o
);
    AST_BUF_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (rst)
        !$stable(rbuf_o) |-> rdy_o); // R4

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (rdy_o && !$past(rdy_o))); // R5

    AST_OVR_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> ($past(rdy_o) && rdy_o)); // R6

    AST_SUM_IS_OR: assert property (@(posedge clk) disable iff (rst)
        sum_o == (ovr_o | frm_o | perr_o)); // R7

    AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !rx_en_i |=> (!rdy_o && !sum_o && !irq_o)); // R8

    AST_RTS_HIGH_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (rts_en_i && !$past(rx_en_i)) |-> rts_n_o); // R12
endmodule

bind uart_rx_mp urx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en_i  (rx_en_i),
    .rts_en_i (rts_en_i),
    .rbuf_o   (rbuf_o),
    .rdy_o    (rdy_o),
    .ovr_o    (ovr_o),
    .frm_o    (frm_o),
    .perr_o   (perr_o),
    .sum_o    (sum_o),
    .irq_o    (irq_o),
    .rts_n_o  (rts_n_o)
);

// File: tb/uart_rx_mp_tb.sv
`timescale 1ns/1ps
module uart_rx_mp_tb;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] len = 2'd1;
    logic [1:0] par = 2'd0;
    logic       two_stop = 1'b0;
    logic       sleep = 1'b0;
    logic       rts_en = 1'b1;
    logic       rd = 1'b0;
    logic [8:0] rbuf;
    logic       rdy, ovr, frm, perr, sum, irq, rts_n;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int tc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tc   <= (tc == 3) ? 0 : tc + 1;
        tick <= (tc == 3);
    end

    always @(negedge clk) if (irq) irq_cnt++;

    uart_rx_mp u_dut (
        .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick), .rx_en_i(rx_en),
        .len_i(len), .par_i(par), .two_stop_i(two_stop), .sleep_i(sleep),
        .rts_en_i(rts_en), .rd_lo_i(rd), .rbuf_o(rbuf), .rdy_o(rdy),
        .ovr_o(ovr), .frm_o(frm), .perr_o(perr), .sum_o(sum), .irq_o(irq),
        .rts_n_o(rts_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic line(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input int pm,
                              input bit ts, input bit bad_par, input bit bad_stop,
                              input bit rts_probe);
        logic p;
        @(negedge clk);
        line(1'b0, BITCLK);
        for (int i = 0; i < nb; i++) begin
            line(d[i], BITCLK / 2);
            if (i == 0 && rts_probe)
                chk(rts_n == 1'b1, "R12", "rts high while receiving", rts_n, 1);
            line(d[i], BITCLK / 2);
        end
        if (pm == 1 || pm == 2) begin
            p = ^d;
            if (pm == 2) p = ~p;
            if (bad_par) p = ~p;
            line(p, BITCLK);
        end
        if (ts) line(1'b1, BITCLK);
        if (bad_stop) begin
            line(1'b0, 44);
            line(1'b1, BITCLK - 44);
        end else begin
            line(1'b1, BITCLK);
        end
        line(1'b1, 96);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(rbuf == 9'h0, "R13", "buffer after reset", rbuf, 0);
        chk({rdy, ovr, frm, perr, sum, irq} == 6'b0, "R13", "flags after reset",
            {rdy, ovr, frm, perr, sum, irq}, 0);
        chk(rts_n == 1'b1, "R13", "rts after reset", rts_n, 1);
        // R12 enable lowers rts one cycle later
        rx_en = 1'b1;
        @(negedge clk);
        chk(rts_n == 1'b0, "R12", "rts low after enable", rts_n, 0);

        // Sweep: every length, parity and stop setting, three words each
        for (int l = 0; l < 3; l++) begin
            for (int p = 0; p < 3; p++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 3; k++) begin
                        int nb;
                        logic [8:0] mask, d;
                        bit bp, bs;
                        nb   = 7 + l;
                        mask = 9'((1 << nb) - 1);
                        case (k)
                            0:       d = mask;
                            1:       d = 9'h155 & mask;
                            default: d = 9'(l * 73 + p * 29 + s * 11 + 6) & mask;
                        endcase
                        bp = (k == 1) && (p != 0);
                        bs = (k == 2);
                        len = 2'(l); par = 2'(p); two_stop = s[0];
                        irq_cnt = 0;
                        send_frame(d, nb, p, s[0], bp, bs, (l == 0 && p == 0 && s == 0 && k == 0));
                        // R1 word placement and zero upper bits
                        chk(rbuf == d, "R1", "buffer word", rbuf, d);
                        chk(rdy == 1'b1, "R4", "ready after frame", rdy, 1);
                        chk(perr == bp, "R2", "parity flag", perr, bp);
                        chk(frm == bs, "R3", "framing flag", frm, bs);
                        chk(sum == (bp | bs), "R7", "summary flag", sum, bp | bs);
                        chk(irq_cnt == 1, "R5", "one irq pulse", irq_cnt, 1);
                        chk(rts_n == 1'b0, "R12", "rts low after frame", rts_n, 0);
                        do_read();
                        // R8 read strobe clears the flags
                        chk({rdy, ovr, frm, perr, sum} == 5'b0, "R8", "flags after read",
                            {rdy, ovr, frm, perr, sum}, 0);
                        chk(rbuf == d, "R4", "buffer kept on read", rbuf, d);
                    end
                end
            end
        end

        // R6 overrun, with R5 no second irq and R8 error accumulation
        len = 2'd1; par = 2'd1; two_stop = 1'b0;
        irq_cnt = 0;
        send_frame(9'h03C, 8, 1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_frame(9'h0A5, 8, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rbuf == 9'h0A5, "R6", "newer word kept", rbuf, 9'h0A5);
        chk(ovr == 1'b1, "R6", "overrun set", ovr, 1);
        chk(perr == 1'b1, "R8", "parity flag accumulates", perr, 1);
        chk(sum == 1'b1, "R7", "summary with overrun", sum, 1);
        chk(irq_cnt == 1, "R5", "no irq on overrun transfer", irq_cnt, 1);
        do_read();
        par = 2'd0;

        // R9 / R10 sleep filtering, 8-bit frames
        sleep = 1'b1;
        irq_cnt = 0;
        send_frame(9'h035, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b0 && rbuf == 9'h0A5, "R9", "8-bit data frame ignored",
            {rdy, rbuf}, {1'b0, 9'h0A5});
        chk(irq_cnt == 0, "R9", "no irq on ignored frame", irq_cnt, 0);
        send_frame(9'h09A, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b1 && rbuf == 9'h09A, "R10", "8-bit address frame taken",
            {rdy, rbuf}, {1'b1, 9'h09A});
        send_frame(9'h012, 8, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk({ovr, frm, rbuf} == {2'b00, 9'h09A}, "R9", "flags untouched by ignored frame",
            {ovr, frm, rbuf}, {2'b00, 9'h09A});
        chk(irq_cnt == 1, "R9", "irq count unchanged", irq_cnt, 1);
        do_read();
        // 7-bit: top bit is bit 6
        len = 2'd0;
        send_frame(9'h03F, 7, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b0, "R9", "7-bit data frame ignored", rdy, 0);
        send_frame(9'h040, 7, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b1 && rbuf == 9'h040, "R10", "7-bit address frame taken",
            {rdy, rbuf}, {1'b1, 9'h040});
        do_read();
        // 9-bit: top bit is bit 8
        len = 2'd2;
        send_frame(9'h0FF, 9, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b0, "R9", "9-bit data frame ignored", rdy, 0);
        send_frame(9'h101, 9, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rdy == 1'b1 && rbuf == 9'h101, "R10", "9-bit address frame taken",
            {rdy, rbuf}, {1'b1, 9'h101});
        do_read();
        sleep = 1'b0;
        len = 2'd1;

        // R11 start glitch
        irq_cnt = 0;
        @(negedge clk);
        line(1'b0, 12);
        line(1'b1, 8);
        chk(rts_n == 1'b0, "R11", "rts unchanged by glitch", rts_n, 0);
        line(1'b1, 200);
        chk(rdy == 1'b0 && rbuf == 9'h101, "R11", "glitch not received",
            {rdy, rbuf}, {1'b0, 9'h101});
        chk(irq_cnt == 0, "R11", "no irq on glitch", irq_cnt, 0);

        // R8 disable clears flags; R12 rts high while disabled
        par = 2'd2;
        send_frame(9'h066, 8, 2, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(rdy && perr, "R2", "odd parity error", {rdy, perr}, 2'b11);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk({rdy, ovr, frm, perr, sum} == 5'b0, "R8", "flags after disable",
            {rdy, ovr, frm, perr, sum}, 0);
        chk(rts_n == 1'b1, "R12", "rts high when disabled", rts_n, 1);
        rts_en = 1'b0;
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(rts_n == 1'b1, "R12", "rts high when output off", rts_n, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule